// File: doc/BRIEF.md
# Single-Word Serial Peripheral Master

This block is a serial peripheral interface master that moves exactly one word per start request. A host gives it a parallel transmit word, a clock divider and four transfer settings: clock idle level, clock phase, word length (8 or 16 bits) and bit order. It then produces the serial clock, the outgoing data line and an active-low slave select, and assembles the incoming data line into a parallel receive word.

The settings and the divider are captured when a start is accepted and stay fixed until that word ends, so the host may change them freely between words. In phase-0 operation the block always returns slave select high after each word and keeps it high for one full serial clock period before another start can be accepted. In phase-1 operation a host-driven hold flag decides whether select stays low after the word, so several words can run under one continuous select.

Top module: `spi_word_master`

## Requirements
- R1: After reset, slave select is high, busy and done are low, and the serial clock sits at the level given by the polarity input.
- R2: Each serial clock half period lasts (divider + 1) system clocks; the first clock edge comes (divider + 1) system clocks after the start is accepted.
- R3: A word is 8 bits when the width input is 0 and 16 bits when it is 1; it has exactly twice that many serial clock edges, slave select stays low throughout, and done rises 2 x bits x (divider + 1) system clocks after acceptance.
- R4: With the order input at 0 the most significant bit travels first on both data lines, with it at 1 the least significant bit travels first; an 8-bit received word appears in bits 7:0 of the receive output with bits 15:8 zero, and an 8-bit transmit word is taken from bits 7:0.
- R5: The serial clock idles at 0 when the polarity input is 0 and at 1 when it is 1, and is back at that level when the word ends.
- R6: In phase 0 the first bit is on the outgoing line before the first clock edge, the incoming line is sampled on odd-numbered edges (first, third, ...) and the outgoing line changes only on even-numbered edges.
- R7: In phase 1 the outgoing line changes only on odd-numbered edges and the incoming line is sampled on even-numbered edges.
- R8: In phase 0, slave select goes high in the cycle done rises and stays high, with busy still high, for 2 x (divider + 1) system clocks; a start during that interval is ignored.
- R9: In phase 1, after a word slave select equals the inverse of the hold input sampled in the done cycle, so it can remain low across successive words.
- R10: Done is high for exactly one system clock, the receive output is valid from that cycle until the next start is accepted, and in phase 1 busy falls in that same cycle.
- R11: A start request while busy is high is ignored and does not reload the transmit word.
- R12: Changes of the settings, divider or transmit word while a word is in progress do not affect that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pol_i | input | 1 | Serial clock idle level |
| cfg_pha_i | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| cfg_wide_i | input | 1 | Word length: 0 = 8 bits, 1 = 16 bits |
| cfg_lsb_i | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| hold_sel_i | input | 1 | Phase-1 only: keep slave select low after the word |
| div_i | input | DIV_W | Half period of the serial clock minus one, in system clocks |
| start_i | input | 1 | Request one word; taken only while busy is low |
| tx_word_i | input | 16 | Word to send |
| busy_o | output | 1 | High from acceptance to the end of the word (and its select gap in phase 0) |
| done_o | output | 1 | One-cycle pulse when the received word is valid |
| rx_word_o | output | 16 | Received word |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Outgoing serial data |
| ssel_n_o | output | 1 | Active-low slave select |
| miso_i | input | 1 | Incoming serial data |

## Verification
The hardest situation to reach is a disturbance that lands inside a running word or inside the phase-0 select gap, since from the ports the block simply ignores it and only a timing or data error would betray a failure. The stimulus sweeps all sixteen setting combinations at three dividers with a bench-side slave that follows the clock edges, and on selected words it raises start while flipping every setting, the divider and the transmit word for a cycle mid-word, then raises start again in the first gap cycle; the word's data, edge count and timing, and a select line that stays high after the gap, expose any leak.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    localparam int WORD_W   = 16;
    localparam int NARROW_W = 8;
    localparam int ECNT_W   = $clog2(2 * WORD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pol;
        logic pha;
        logic wide;
        logic lsb;
    } xfer_cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } timer_t;

    timer_t d, q;

    assign tick_o = run_i && (q.cnt == div_i);

    always_comb begin
        d = q;
        if (!run_i || tick_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: the half-period count never passes the captured divider
    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (q.cnt <= div_i));

    // R2: an idle timer restarts from zero
    assert_timer_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (q.cnt == '0));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
    import spi_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              wide_i,
    input  logic              lsb_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_word_o
);

    localparam int TOP_WIDE   = WORD_W - 1;
    localparam int TOP_NARROW = NARROW_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } shreg_t;

    shreg_t d, q;
    int     ins_pos;

    always_comb begin
        if (lsb_i) begin
            mosi_o = q.tx[0];
        end else if (wide_i) begin
            mosi_o = q.tx[TOP_WIDE];
        end else begin
            mosi_o = q.tx[TOP_NARROW];
        end
    end

    generate
        if (WORD_W > NARROW_W) begin : g_mask
            assign rx_word_o = wide_i ? q.rx
                             : {{(WORD_W-NARROW_W){1'b0}}, q.rx[NARROW_W-1:0]};
        end else begin : g_nomask
            assign rx_word_o = q.rx;
        end
    endgenerate

    always_comb begin
        d       = q;
        ins_pos = wide_i ? TOP_WIDE : TOP_NARROW;
        if (load_i) begin
            d.tx = tx_word_i;
            d.rx = '0;
        end else begin
            if (shift_i) begin
                d.tx = lsb_i ? (q.tx >> 1) : (q.tx << 1);
            end
            if (sample_i) begin
                if (lsb_i) begin
                    d.rx          = q.rx >> 1;
                    d.rx[ins_pos] = miso_i;
                end else begin
                    d.rx = {q.rx[WORD_W-2:0], miso_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: a word is never loaded in the same cycle as a data movement
    assert_load_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!shift_i && !sample_i));

    // R7: outgoing data stays put when no shift or load occurs
    assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(q.tx));

endmodule

// File: rtl/spi_word_seq.sv
module spi_word_seq
    import spi_word_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  xfer_cfg_t        cfg_i,
    input  logic             hold_sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic [DIV_W-1:0] div_q_o,
    output xfer_cfg_t        cfg_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             sck_o,
    output logic             ssel_n_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [ECNT_W-1:0] EDGES_WIDE   = ECNT_W'(2 * WORD_W);
    localparam logic [ECNT_W-1:0] EDGES_NARROW = ECNT_W'(2 * NARROW_W);
    localparam logic [ECNT_W-1:0] ONE          = ECNT_W'(1);

    typedef struct packed {
        seq_state_e        st;
        xfer_cfg_t         cfg;
        logic [DIV_W-1:0]  div;
        logic [ECNT_W-1:0] ecnt;
        logic              sck;
        logic              ssel_n;
        logic              busy;
        logic              done;
    } seq_t;

    seq_t              d, q;
    logic [ECNT_W-1:0] k;
    logic [ECNT_W-1:0] last_edge;
    logic              lead;

    assign last_edge = q.cfg.wide ? EDGES_WIDE : EDGES_NARROW;
    assign k         = q.ecnt + ONE;
    assign lead      = k[0];

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        load_o   = 1'b0;
        shift_o  = 1'b0;
        sample_o = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.sck = cfg_i.pol;
                if (start_i) begin
                    d.st     = ST_RUN;
                    d.cfg    = cfg_i;
                    d.div    = div_i;
                    d.ecnt   = '0;
                    d.ssel_n = 1'b0;
                    d.busy   = 1'b1;
                    load_o   = 1'b1;
                end
            end
            ST_RUN: begin
                if (tick_i) begin
                    d.sck  = ~q.sck;
                    d.ecnt = k;
                    if (q.cfg.pha) begin
                        shift_o  = lead && (k != ONE);
                        sample_o = !lead;
                    end else begin
                        shift_o  = !lead && (k != last_edge);
                        sample_o = lead;
                    end
                    if (k == last_edge) begin
                        d.done = 1'b1;
                        d.ecnt = '0;
                        if (q.cfg.pha) begin
                            d.st     = ST_IDLE;
                            d.busy   = 1'b0;
                            d.ssel_n = ~hold_sel_i;
                        end else begin
                            d.st     = ST_GAP;
                            d.ssel_n = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    d.ecnt = k;
                    if (q.ecnt == ONE) begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.ecnt = '0;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ssel_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign run_o    = (q.st != ST_IDLE);
    assign div_q_o  = q.div;
    assign cfg_o    = q.cfg;
    assign sck_o    = q.sck;
    assign ssel_n_o = q.ssel_n;
    assign busy_o   = q.busy;
    assign done_o   = q.done;

    // R10: done lasts a single system clock
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R3: select is low for the whole word
    assert_sel_in_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> !q.ssel_n);

    // R3: the edge count never passes the word's edge total
    assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> (q.ecnt < last_edge));

    // R8: the phase-0 gap keeps select high and busy set
    assert_gap_sel_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> (q.ssel_n && q.busy));

    // R5: the clock rests at its idle level during the gap
    assert_gap_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> (q.sck == q.cfg.pol));

    // R12: captured settings hold while a word runs
    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |=> $stable(q.cfg) && $stable(q.div));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pol_i,
    input  logic              cfg_pha_i,
    input  logic              cfg_wide_i,
    input  logic              cfg_lsb_i,
    input  logic              hold_sel_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              ssel_n_o,
    input  logic              miso_i
);

    xfer_cfg_t        cfg_in;
    xfer_cfg_t        cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             run;
    logic             tick;
    logic             load;
    logic             shift;
    logic             sample;

    assign cfg_in = '{pol: cfg_pol_i, pha: cfg_pha_i, wide: cfg_wide_i, lsb: cfg_lsb_i};

    spi_word_seq #(.DIV_W(DIV_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cfg_i      (cfg_in),
        .hold_sel_i (hold_sel_i),
        .div_i      (div_i),
        .tick_i     (tick),
        .run_o      (run),
        .div_q_o    (div_q),
        .cfg_o      (cfg_q),
        .load_o     (load),
        .shift_o    (shift),
        .sample_o   (sample),
        .sck_o      (sck_o),
        .ssel_n_o   (ssel_n_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_q),
        .tick_o (tick)
    );

    spi_shift_unit u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .tx_word_i (tx_word_i),
        .wide_i    (cfg_q.wide),
        .lsb_i     (cfg_q.lsb),
        .shift_i   (shift),
        .sample_i  (sample),
        .miso_i    (miso_i),
        .mosi_o    (mosi_o),
        .rx_word_o (rx_word_o)
    );

    // R4: a narrow received word leaves the upper byte clear
    assert_rx_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cfg_q.wide) |-> (rx_word_o[WORD_W-1:NARROW_W] == '0));

    // R11: busy never drops while the serial clock is away from idle
    assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && run) |-> (sck_o == cfg_q.pol));

endmodule

// File: tb/spi_word_master_test.sv
`timescale 1ns/1ps
module spi_word_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pol = 1'b1;
    logic        cfg_pha = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_lsb = 1'b0;
    logic        hold_sel = 1'b0;
    logic [7:0]  div = 8'd0;
    logic        start = 1'b0;
    logic [15:0] tx_word = 16'h0000;
    logic        busy;
    logic        done;
    logic [15:0] rx_word;
    logic        sck;
    logic        mosi;
    logic        ssel_n;
    logic        miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_word_master #(.DIV_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pol_i  (cfg_pol),
        .cfg_pha_i  (cfg_pha),
        .cfg_wide_i (cfg_wide),
        .cfg_lsb_i  (cfg_lsb),
        .hold_sel_i (hold_sel),
        .div_i      (div),
        .start_i    (start),
        .tx_word_i  (tx_word),
        .busy_o     (busy),
        .done_o     (done),
        .rx_word_o  (rx_word),
        .sck_o      (sck),
        .mosi_o     (mosi),
        .ssel_n_o   (ssel_n),
        .miso_i     (miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_word(input bit pol, input bit pha, input bit wide, input bit lsb,
                            input bit hold, input int dv, input logic [15:0] tx,
                            input logic [15:0] sw, input bit disturb);
        int          n = wide ? 16 : 8;
        int          h = dv + 1;
        int          c;
        int          edges = 0;
        int          idx;
        bit          timing_ok = 1;
        bit          mosi_ok = 1;
        bit          sel_ok = 1;
        bit          seen_done = 0;
        bit          prev_sck;
        bit          prev_mosi;
        bit          is_edge;
        bit          lead;
        bit          may_change;
        logic [15:0] got = 16'h0000;
        logic [15:0] exp_tx = wide ? tx : {8'h00, tx[7:0]};
        logic [15:0] exp_rx = wide ? sw : {8'h00, sw[7:0]};
        bit          first_tx = lsb ? tx[0] : tx[n-1];

        @(negedge clk);
        cfg_pol = pol; cfg_pha = pha; cfg_wide = wide; cfg_lsb = lsb;
        hold_sel = hold; div = 8'(dv); tx_word = tx; start = 1'b1;
        miso = lsb ? sw[0] : sw[n-1];
        @(negedge clk);
        start = 1'b0;
        c = 1;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        chk(ssel_n == 1'b0, "R3", "select low at word start", ssel_n, 0);
        chk(sck == pol, "R5", "clock idle at word start", sck, pol);
        if (pha == 1'b0)
            chk(mosi == first_tx, "R6", "first bit before first edge", mosi, first_tx);
        prev_sck  = sck;
        prev_mosi = mosi;
        while (!seen_done && c < 2 * n * h + 10) begin
            @(negedge clk);
            c++;
            if (disturb && c == 2) begin
                start = 1'b1; tx_word = ~tx; cfg_pol = ~pol; cfg_pha = ~pha;
                cfg_wide = ~wide; cfg_lsb = ~lsb; div = 8'(dv + 2);
            end
            if (disturb && c == 3) begin
                start = 1'b0; tx_word = tx; cfg_pol = pol; cfg_pha = pha;
                cfg_wide = wide; cfg_lsb = lsb; div = 8'(dv);
            end
            is_edge    = (sck != prev_sck);
            may_change = 1'b0;
            if (is_edge) begin
                edges++;
                if (c != edges * h + 1) timing_ok = 0;
                lead = edges[0];
                idx  = (edges - 1) / 2;
                if ((pha == 1'b0 && lead) || (pha == 1'b1 && !lead)) begin
                    if (idx < n) got[lsb ? idx : n - 1 - idx] = mosi;
                end
                if (pha == 1'b0 && !lead) begin
                    may_change = (edges < 2 * n);
                    if (edges / 2 < n) miso = lsb ? sw[edges/2] : sw[n - 1 - edges/2];
                end
                if (pha == 1'b1 && lead) begin
                    may_change = 1'b1;
                    if (idx < n) miso = lsb ? sw[idx] : sw[n - 1 - idx];
                end
            end
            if (mosi != prev_mosi && !may_change) mosi_ok = 0;
            if (ssel_n && !done) sel_ok = 0;
            prev_sck  = sck;
            prev_mosi = mosi;
            if (done) seen_done = 1;
        end
        chk(seen_done && c == 2 * n * h + 1, "R3", "cycles to done", c, 2 * n * h + 1);
        chk(edges == 2 * n, "R3", "clock edge count", edges, 2 * n);
        chk(timing_ok, "R2", "edge spacing", timing_ok, 1);
        chk(sel_ok, "R3", "select held low during word", sel_ok, 1);
        chk(got == exp_tx, "R4", "serial word sent", got, exp_tx);
        chk(rx_word == exp_rx, "R4", "received word", rx_word, exp_rx);
        chk(sck == pol, "R5", "clock idle at word end", sck, pol);
        if (pha == 1'b0) chk(mosi_ok, "R6", "outgoing changes only on even edges", mosi_ok, 1);
        else             chk(mosi_ok, "R7", "outgoing changes only on odd edges", mosi_ok, 1);
        if (disturb) chk(got == exp_tx && rx_word == exp_rx && edges == 2 * n,
                         "R12", "mid-word input changes ignored", got, exp_tx);
        if (pha == 1'b0) begin
            chk(ssel_n == 1'b1 && busy == 1'b1, "R8", "gap starts with done",
                {ssel_n, busy}, 2'b11);
            if (disturb) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(done == 1'b0, "R10", "done single pulse", done, 0);
            chk(rx_word == exp_rx, "R10", "received word still valid", rx_word, exp_rx);
            repeat (2 * h - 2) @(negedge clk);
            chk(busy == 1'b1 && ssel_n == 1'b1, "R8", "gap last cycle",
                {busy, ssel_n}, 2'b11);
            @(negedge clk);
            chk(busy == 1'b0 && ssel_n == 1'b1, "R8", "gap ends", {busy, ssel_n}, 2'b01);
            @(negedge clk);
            chk(ssel_n == 1'b1 && busy == 1'b0, "R11", "start in gap not taken",
                {ssel_n, busy}, 2'b10);
        end else begin
            chk(busy == 1'b0, "R10", "busy falls with done", busy, 0);
            chk(ssel_n == !hold, "R9", "select follows hold flag", ssel_n, !hold);
            @(negedge clk);
            chk(done == 1'b0, "R10", "done single pulse", done, 0);
            chk(ssel_n == !hold, "R9", "select keeps hold level", ssel_n, !hold);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ssel_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "reset outputs",
            {ssel_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck == 1'b1, "R1", "idle clock follows polarity 1", sck, 1);
        cfg_pol = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0, "R5", "idle clock follows polarity 0", sck, 0);
        chk(ssel_n == 1'b1 && busy == 1'b0, "R1", "idle after release",
            {ssel_n, busy}, 2'b10);

        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int dsel = 0; dsel < 3; dsel++) begin
                int          dv = (dsel == 0) ? 0 : (dsel == 1 ? 1 : 3);
                logic [15:0] tx = 16'hA5C3 ^ 16'(cfg * 16'h1111) ^ 16'(dv);
                logic [15:0] sw = 16'h3C96 + 16'(cfg * 37) + 16'(dv * 101);
                run_word(cfg[0], cfg[1], cfg[2], cfg[3], dsel == 1, dv, tx, sw,
                         (cfg % 5) == 0);
            end
        end

        // R9: two phase-1 words under one continuous select
        run_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1, 16'hBEEF, 16'h1234, 1'b0);
        repeat (4) @(negedge clk);
        chk(ssel_n == 1'b0, "R9", "select held low between words", ssel_n, 0);
        run_word(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2, 16'h00C5, 16'h005A, 1'b1);
        repeat (2) @(negedge clk);
        chk(ssel_n == 1'b1, "R9", "select released with hold clear", ssel_n, 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule